// File: doc/BRIEF.md
# Burst-mode resolution sequencer

This block steers an ADC output stream that alternates between a full 12-bit phase and a reduced-resolution phase of 7 or 11 bits. It counts accepted output samples and drives a select line that tells the downstream formatter which path to use. One exponent N sets both phase lengths: a full-resolution phase lasts 2^N samples and a reduced phase lasts 2^(N+3) samples, which is eight times as long. Only the control is in scope. The converter, the register access and the data reformatting belong to neighbouring blocks.

When burst operation is switched on, the block first sends a fixed reduced-resolution run of 2^13 samples, and it does not accept a trigger during that run. After that run, and after every later reduced phase, the next full-resolution phase starts in one of two ways. In automatic mode it starts at once. In manual mode it starts when an external trigger arrives. A new exponent can be written at any time. It is held pending and takes effect only at the start of the next output cycle, and each output cycle begins with its reduced phase.

Top module: `burst_res_seq`

## Requirements
- R1: After reset, and whenever burst enable is low, the block is idle: hiRes=0, phaseStart=0 and trigLocked=0. The pending and active exponents both reset to N_RST (default 10).
- R2: In the cycle after burst enable is first seen high, the lockout run begins with trigLocked=1, hiRes=0 and phaseStart=1. It lasts exactly 2^LOCK_EXP (default 2^13) strobes of sampleValid.
- R3: Phase progress advances only on cycles where sampleValid=1. The internal sample counter never exceeds 2^(N_MAX+3)-1.
- R4: A full-resolution phase shows hiRes=1 (1 selects the 12-bit path) for exactly 2^N valid strobes.
- R5: A reduced phase that follows a full-resolution phase shows hiRes=0 for exactly 2^(N+3) valid strobes.
- R6: With autoMode=1, hiRes rises in the cycle right after the last valid strobe of the lockout run or of a reduced phase.
- R7: With autoMode=0, once the lockout run or a reduced phase completes, hiRes stays 0 until trigIn=1 is sampled. hiRes then rises in the next cycle. If autoMode is raised while waiting, the full-resolution phase also starts in the next cycle.
- R8: trigIn is ignored during the lockout run, during a full-resolution phase and during a reduced phase. It acts only while the block is waiting after such a phase.
- R9: A pulse on nWrEn stores nWrData as the pending exponent. The active exponent loads from the pending one only when burst enable rises and when a reduced phase starts after a full-resolution phase.
- R10: A written exponent below N_MIN (10) is stored as N_MIN, and one above N_MAX (25) is stored as N_MAX.
- R11: Dropping burst enable returns the block to idle in the next cycle from any state. Raising it again restarts a complete lockout run.
- R12: phaseStart is a one-cycle pulse in the first cycle of every lockout run, full-resolution phase and reduced phase. It stays 0 when the block only starts waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| burstEn | input | 1 | Burst operation enable |
| autoMode | input | 1 | 1 = automatic trigger, 0 = manual trigger |
| trigIn | input | 1 | External trigger for the full-resolution phase |
| nWrEn | input | 1 | Write strobe for the exponent |
| nWrData | input | N_W (5) | Exponent value to write |
| sampleValid | input | 1 | One output sample accepted in this cycle |
| hiRes | output | 1 | 1 = 12-bit path, 0 = reduced path |
| phaseStart | output | 1 | First cycle of a new phase |
| trigLocked | output | 1 | Lockout run in progress |

## Verification
Every output is a register. A change in enable, a trigger or the last valid strobe of a phase therefore shows up exactly one clock after the edge that samples it. The bench drives inputs on the falling edge and reads outputs on the falling edge that follows the next rising edge. Phase lengths are counted in accepted strobes, not in cycles, so sweeps with continuous and gapped sampleValid must give the same length. The bench is built with small exponent limits, so it can sweep every legal exponent and both clamp limits in full, with lengths computed as powers of two.

// File: rtl/burst_res_pkg.sv
package burst_res_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOCK = 3'd1,
    ST_HI   = 3'd2,
    ST_LO   = 3'd3,
    ST_WAIT = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;   // restart phase counter
    logic latchN;   // copy pending exponent into active exponent
    logic selHi;    // current phase is full resolution
    logic selLock;  // current phase is the lockout run
  } seqStrobe_t;

endpackage

// File: rtl/burst_res_dpath.sv
module burst_res_dpath
  import burst_res_pkg::*;
#(
  parameter int N_MIN    = 10,
  parameter int N_MAX    = 25,
  parameter int N_RST    = 10,
  parameter int LOCK_EXP = 13,
  parameter int N_W      = 5,
  parameter int CNT_W    = 29
) (
  input  logic           clk,
  input  logic           rstN,
  input  seqStrobe_t     strobe,
  input  logic           sampleValid,
  input  logic           nWrEn,
  input  logic [N_W-1:0] nWrData,
  output logic           lastSample
);
  localparam int EXP_W = $clog2(N_MAX + 4);

  logic [N_W-1:0]   nPend;
  logic [N_W-1:0]   nCur;
  logic [CNT_W-1:0] sampleCnt;
  logic [EXP_W-1:0] curExp;
  logic [CNT_W-1:0] lastCount;

  function automatic logic [N_W-1:0] clampN(input logic [N_W-1:0] v);
    if (v < N_W'(N_MIN))      return N_W'(N_MIN);
    else if (v > N_W'(N_MAX)) return N_W'(N_MAX);
    else                      return v;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nPend <= N_W'(N_RST);
      nCur  <= N_W'(N_RST);
    end else begin
      if (nWrEn)         nPend <= clampN(nWrData);
      if (strobe.latchN) nCur  <= nPend;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sampleCnt <= '0;
    else if (strobe.clrCnt) sampleCnt <= '0;
    else if (sampleValid)   sampleCnt <= sampleCnt + CNT_W'(1);
  end

  always_comb begin
    if (strobe.selLock)    curExp = EXP_W'(LOCK_EXP);
    else if (strobe.selHi) curExp = EXP_W'(nCur);
    else                   curExp = EXP_W'(nCur) + EXP_W'(3);
  end

  assign lastCount  = (CNT_W'(1) << curExp) - CNT_W'(1);
  assign lastSample = (sampleCnt == lastCount);

endmodule

// File: rtl/burst_res_ctrl.sv
module burst_res_ctrl
  import burst_res_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       burstEn,
  input  logic       autoMode,
  input  logic       trigIn,
  input  logic       sampleValid,
  input  logic       lastSample,
  output seqStrobe_t strobe,
  output logic       hiRes,
  output logic       phaseStart,
  output logic       trigLocked
);
  seqState_t state, nextState;
  logic      phaseEnd;
  logic      startNext;

  assign phaseEnd = sampleValid && lastSample;

  always_comb begin
    nextState = state;
    if (!burstEn) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: nextState = ST_LOCK;
        ST_LOCK: if (phaseEnd) nextState = autoMode ? ST_HI : ST_WAIT;
        ST_HI:   if (phaseEnd) nextState = ST_LO;
        ST_LO:   if (phaseEnd) nextState = autoMode ? ST_HI : ST_WAIT;
        ST_WAIT: if (trigIn || autoMode) nextState = ST_HI;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign startNext = (nextState != state) &&
                     (nextState == ST_LOCK || nextState == ST_HI || nextState == ST_LO);

  always_comb begin
    strobe.clrCnt  = (nextState != state) || (state == ST_IDLE) || (state == ST_WAIT);
    strobe.latchN  = (state == ST_IDLE && nextState == ST_LOCK) ||
                     (state == ST_HI && nextState == ST_LO);
    strobe.selHi   = (state == ST_HI);
    strobe.selLock = (state == ST_LOCK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phaseStart <= 1'b0;
    end else begin
      state      <= nextState;
      phaseStart <= startNext;
    end
  end

  assign hiRes      = (state == ST_HI);
  assign trigLocked = (state == ST_LOCK);

endmodule

// File: rtl/burst_res_seq.sv
module burst_res_seq
  import burst_res_pkg::*;
#(
  parameter int N_MIN    = 10,
  parameter int N_MAX    = 25,
  parameter int N_RST    = 10,
  parameter int LOCK_EXP = 13,
  parameter int N_W      = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           burstEn,
  input  logic           autoMode,
  input  logic           trigIn,
  input  logic           nWrEn,
  input  logic [N_W-1:0] nWrData,
  input  logic           sampleValid,
  output logic           hiRes,
  output logic           phaseStart,
  output logic           trigLocked
);
  localparam int CNT_W = N_MAX + 4;

  seqStrobe_t strobe;
  logic       lastSample;

  burst_res_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .burstEn     (burstEn),
    .autoMode    (autoMode),
    .trigIn      (trigIn),
    .sampleValid (sampleValid),
    .lastSample  (lastSample),
    .strobe      (strobe),
    .hiRes       (hiRes),
    .phaseStart  (phaseStart),
    .trigLocked  (trigLocked)
  );

  burst_res_dpath #(
    .N_MIN    (N_MIN),
    .N_MAX    (N_MAX),
    .N_RST    (N_RST),
    .LOCK_EXP (LOCK_EXP),
    .N_W      (N_W),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sampleValid (sampleValid),
    .nWrEn       (nWrEn),
    .nWrData     (nWrData),
    .lastSample  (lastSample)
  );

endmodule

// File: rtl/burst_res_seq_chk.sv
module burst_res_seq_chk #(
  parameter int N_MAX = 25,
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rstN,
  input logic             burstEn,
  input logic             autoMode,
  input logic             trigIn,
  input logic             sampleValid,
  input logic             hiRes,
  input logic             phaseStart,
  input logic             trigLocked,
  input logic [CNT_W-1:0] sampleCnt
);
  localparam logic [CNT_W-1:0] CNT_LIMIT = (CNT_W'(1) << (N_MAX + 3)) - CNT_W'(1);

  // R11 / R1: disabled means idle one cycle later
  p_idle_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !burstEn |=> (!hiRes && !trigLocked && !phaseStart));

  // R2: lockout and full resolution never overlap
  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    hiRes |-> !trigLocked);

  // R12: a start pulse always accompanies a phase boundary
  p_start_edge_r12: assert property (@(posedge clk) disable iff (!rstN)
    phaseStart |-> ((hiRes != $past(hiRes)) || $rose(trigLocked)));

  // R7 / R6: full resolution begins only through auto mode or a trigger
  p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiRes) |-> ($past(autoMode) || $past(trigIn)));

  // R3: a full-resolution phase ends only on an accepted strobe or on disable
  p_fall_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hiRes) |-> ($past(sampleValid) || !$past(burstEn)));

  // R3: counter stays within the longest phase
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    sampleCnt <= CNT_LIMIT);

endmodule

bind burst_res_seq burst_res_seq_chk #(
  .N_MAX (N_MAX),
  .CNT_W (N_MAX + 4)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .burstEn     (burstEn),
  .autoMode    (autoMode),
  .trigIn      (trigIn),
  .sampleValid (sampleValid),
  .hiRes       (hiRes),
  .phaseStart  (phaseStart),
  .trigLocked  (trigLocked),
  .sampleCnt   (u_dp.sampleCnt)
);

// File: tb/burst_res_seq_bench.sv
`timescale 1ns/1ps
module burst_res_seq_bench;
  localparam int N_MIN = 2, N_MAX = 5, N_RST = 3, LOCK_EXP = 4, N_W = 5;
  localparam int LOCK_LEN = 2 ** LOCK_EXP;

  logic clk = 1'b0, rstN = 1'b0;
  logic burstEn = 1'b0, autoMode = 1'b1, trigIn = 1'b0, nWrEn = 1'b0, sampleValid = 1'b0;
  logic [N_W-1:0] nWrData = '0;
  logic hiRes, phaseStart, trigLocked;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_res_seq #(.N_MIN(N_MIN), .N_MAX(N_MAX), .N_RST(N_RST),
                  .LOCK_EXP(LOCK_EXP), .N_W(N_W)) u_burst_res_seq (
    .clk(clk), .rstN(rstN), .burstEn(burstEn), .autoMode(autoMode),
    .trigIn(trigIn), .nWrEn(nWrEn), .nWrData(nWrData),
    .sampleValid(sampleValid), .hiRes(hiRes), .phaseStart(phaseStart),
    .trigLocked(trigLocked));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic bit inPhase(input int kind);
    if (kind == 0)      return trigLocked;
    else if (kind == 1) return hiRes;
    else                return !hiRes && !trigLocked;
  endfunction

  // counts accepted strobes while the phase lasts; entered and left at negedge
  task automatic measure(input int kind, input bit gapped, output int n, output bit st);
    int cyc = 0;
    n = 0;
    st = phaseStart;
    while (inPhase(kind) && cyc < 5000) begin
      bit v;
      v = gapped ? ((cyc % 3) != 1) : 1'b1;
      sampleValid = v;
      @(posedge clk);
      if (v) n++;
      cyc++;
      @(negedge clk);
    end
    sampleValid = 1'b0;
  endtask

  task automatic writeN(input int v);
    nWrData = N_W'(v); nWrEn = 1'b1;
    tick();
    nWrEn = 1'b0;
  endtask

  task automatic restart();
    burstEn = 1'b0; tick();
    burstEn = 1'b1; tick();
  endtask

  // one automatic cycle: lockout, high, low, high
  task automatic autoRun(input int nExp, input bit gapped, input string tag);
    int n; bit st;
    autoMode = 1'b1;
    restart();
    check(trigLocked && phaseStart && !hiRes, "R2 lockout start", trigLocked, 1);
    measure(0, gapped, n, st);
    check(n == LOCK_LEN, "R2 lockout length", n, LOCK_LEN);
    check(hiRes, "R6 auto high after lockout", hiRes, 1);
    measure(1, gapped, n, st);
    check(n == 2 ** nExp, {"R4 high length ", tag}, n, 2 ** nExp);
    check(st, "R12 start on high", st, 1);
    measure(2, gapped, n, st);
    check(n == 2 ** (nExp + 3), {"R5 low length ", tag}, n, 2 ** (nExp + 3));
    check(st, "R12 start on low", st, 1);
    measure(1, gapped, n, st);
    check(n == 2 ** nExp, {"R6 auto repeat high ", tag}, n, 2 ** nExp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int n; bit st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!hiRes && !phaseStart && !trigLocked, "R1 reset idle", hiRes + phaseStart + trigLocked, 0);

    // R1 default exponent
    autoRun(N_RST, 1'b0, "reset N");

    // R4 R5 sweep of legal exponents, continuous and gapped strobes (R3)
    for (int e = N_MIN; e <= N_MAX; e++) begin
      writeN(e);
      autoRun(e, 1'b0, "sweep");
      writeN(e);
      autoRun(e, 1'b1, "R3 gapped");
    end

    // R10 clamping
    writeN(0);  autoRun(N_MIN, 1'b0, "R10 clamp low");
    writeN(31); autoRun(N_MAX, 1'b0, "R10 clamp high");

    // R9 write during high: current high and pending low
    writeN(2);
    autoMode = 1'b1;
    restart();
    measure(0, 1'b0, n, st);
    writeN(4);
    check(hiRes, "R9 still high after write", hiRes, 1);
    measure(1, 1'b0, n, st);
    check(n == 4, "R9 high keeps old N", n, 4);
    measure(2, 1'b0, n, st);
    check(n == 128, "R9 low uses new N", n, 128);
    measure(1, 1'b0, n, st);
    check(n == 16, "R9 next high uses new N", n, 16);

    // R11 disable mid-phase and restart
    sampleValid = 1'b1; tick(); sampleValid = 1'b0;
    burstEn = 1'b0; tick();
    check(!hiRes && !trigLocked && !phaseStart, "R11 idle after disable", hiRes, 0);
    burstEn = 1'b1; tick();
    check(trigLocked && phaseStart, "R11 restart lockout", trigLocked, 1);
    measure(0, 1'b0, n, st);
    check(n == LOCK_LEN, "R11 full lockout again", n, LOCK_LEN);

    // R7 R8 manual mode
    writeN(2);
    autoMode = 1'b0;
    restart();
    trigIn = 1'b1;
    measure(0, 1'b0, n, st);
    trigIn = 1'b0;
    check(n == LOCK_LEN, "R8 lockout ignores trigger", n, LOCK_LEN);
    check(!hiRes, "R8 trigger in lockout no effect", hiRes, 0);
    sampleValid = 1'b1;
    repeat (20) tick();
    sampleValid = 1'b0;
    check(!hiRes && !phaseStart, "R7 wait without trigger", hiRes, 0);
    trigIn = 1'b1; tick(); trigIn = 1'b0;
    check(hiRes && phaseStart, "R7 high after trigger", hiRes, 1);
    trigIn = 1'b1;
    measure(1, 1'b0, n, st);
    trigIn = 1'b0;
    check(n == 4, "R8 high ignores trigger", n, 4);
    sampleValid = 1'b1;
    repeat (31) tick();
    sampleValid = 1'b0;
    trigIn = 1'b1; tick(); trigIn = 1'b0;
    check(!hiRes, "R8 low phase ignores trigger", hiRes, 0);
    sampleValid = 1'b1; tick(); sampleValid = 1'b0;
    check(!hiRes && !phaseStart, "R12 no start on wait", phaseStart, 0);
    tick();
    check(!hiRes, "R5 manual low then wait", hiRes, 0);
    autoMode = 1'b1; tick();
    check(hiRes && phaseStart, "R7 auto raised in wait", hiRes, 1);

    burstEn = 1'b0; tick();
    check(!hiRes && !trigLocked, "R1 idle at end", hiRes, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule